// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

The block is a watchdog timer driven by a single 32-bit control word and observed through a status word. Both sit on a simple word-wide register port. The control word holds three fields: a reload count, a command bit that starts or stops counting, and a 7-bit key. While the stored command bit is set, the watchdog is armed. A new control word is then taken only if its key is the bitwise inverse of the key already held. Any other write is dropped without trace. Each accepted control word therefore has to carry the inverse of the previous one, and a runaway program that rewrites a constant cannot keep the timer alive.

The counter steps down once for every cycle in which the slow tick enable is high. The tick generator is outside the block; ticks arrive at roughly 760 per second. When the count runs out the first time, the block raises its non-maskable interrupt line and reloads a short grace count. If the grace count also runs out before software services the timer, the block emits a one-cycle reset request and stops. Any accepted control write clears the interrupt stage and reloads the counter.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0, the counter is stopped, and both nmi and rst_req are low.
- R2: While the stored command bit (control bit 8) is 0, a control write is accepted whatever its key (bits [15:9]).
- R3: While the stored command bit is 1, a control write whose key is not the bitwise inverse of the stored key is discarded: the count, the run state and the stored word do not change.
- R4: While the stored command bit is 1, a control write whose key equals the bitwise inverse of the stored key is accepted.
- R5: An accepted write loads the counter from bits [7:0]; a value of 0 loads 256. The count is visible in status bits [8:0].
- R6: With the command bit of the accepted write at 1, the count drops by one per tick and status bit 13 reads 1; with it at 0, the counter holds and ticks have no effect.
- R7: A tick with the count at 1 and no interrupt pending sets nmi (status bit 12) and reloads the count with GRACE on the next cycle.
- R8: A tick with the count at 1 while nmi is set produces rst_req high for exactly one cycle, then the counter stops at 0.
- R9: An accepted control write clears nmi.
- R10: A control write accepted in the same cycle as a tick wins: the count equals the written load value, not one less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow count enable, one pulse per watchdog step |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address; CTRL_OFS selects control, STAT_OFS selects status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| nmi | output | 1 | Non-maskable interrupt, high from first expiry until serviced |
| rst_req | output | 1 | One-cycle system reset request on second expiry |

## Verification
The key check is exercised with three kinds of write. A write made while the timer is disarmed with an arbitrary key shows that arming is what enables the guard. A write that repeats the stored key, which is a plausible runaway pattern, must be dropped. A write with the inverted key must be taken, and the check is repeated across a chain of alternating keys. The countdown is run to a first expiry and then to a second one to separate the interrupt stage from the reset stage. The checks also cover a stopped counter under ticks, a zero count field read as 256, and a write that coincides with a tick.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_FIELD_W  = 8;
  localparam int KEY_W        = 7;
  localparam int CMD_BIT      = CNT_FIELD_W;
  localparam int KEY_LSB      = CNT_FIELD_W + 1;
  localparam int CNT_W        = CNT_FIELD_W + 1;
  localparam int STAT_NMI_BIT = 12;
  localparam int STAT_RUN_BIT = 13;

  // Count field of zero means the full 2**CNT_FIELD_W span.
  function automatic logic [CNT_W-1:0] reload_count(input logic [CNT_FIELD_W-1:0] f);
    return (f == '0) ? {1'b1, {CNT_FIELD_W{1'b0}}} : {1'b0, f};
  endfunction

  // Armed writes must carry the inverse of the held key.
  function automatic logic key_matches(input logic [KEY_W-1:0] held,
                                       input logic [KEY_W-1:0] fresh);
    return fresh == ~held;
  endfunction

  function automatic logic [31:0] status_word(input logic [CNT_W-1:0] cnt,
                                              input logic stage, input logic run);
    logic [31:0] w;
    w = '0;
    w[CNT_W-1:0]     = cnt;
    w[STAT_NMI_BIT]  = stage;
    w[STAT_RUN_BIT]  = run;
    return w;
  endfunction
endpackage

// File: rtl/wdg_keyguard.sv
module wdg_keyguard
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl_q,
  output logic        accept
);
  logic armed;
  logic key_ok;

  assign armed  = ctrl_q[CMD_BIT];
  assign key_ok = key_matches(ctrl_q[KEY_LSB +: KEY_W], wdata[KEY_LSB +: KEY_W]);
  assign accept = ctrl_wr && (!armed || key_ok);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (accept) ctrl_q <= wdata;
  end

  // R2
  disarmed_write_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_q[CMD_BIT]) |=> (ctrl_q == $past(wdata)));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int GRACE = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run_cmd,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             stage,
  output logic             rst_req,
  output logic             first_exp,
  output logic             second_exp
);
  localparam logic [CNT_W-1:0] GRACE_V = CNT_W'(GRACE);

  logic step;
  logic expiry;

  assign step       = running && tick && !load;
  assign expiry     = step && (cnt <= CNT_W'(1));
  assign first_exp  = expiry && !stage;
  assign second_exp = expiry && stage;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      stage   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (load) begin
        cnt     <= load_val;
        running <= run_cmd;
        stage   <= 1'b0;
      end else if (first_exp) begin
        stage <= 1'b1;
        cnt   <= GRACE_V;
      end else if (second_exp) begin
        rst_req <= 1'b1;
        running <= 1'b0;
        cnt     <= '0;
      end else if (step) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(cnt));
  // R7
  nmi_grace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage) |-> (cnt == GRACE_V));
  // R8
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R9
  service_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !stage);
  // R5
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt != '0));
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
  import wdg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 'h40,
  parameter int STAT_OFS = 'h44,
  parameter int GRACE    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              nmi,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  logic             ctrl_wr;
  logic             accept;
  logic [31:0]      ctrl_q;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             stage;
  logic             first_exp;
  logic             second_exp;

  assign ctrl_wr = wr_en && (addr == CTRL_A);

  wdg_keyguard u_guard (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(wdata),
    .ctrl_q(ctrl_q), .accept(accept)
  );

  wdg_counter #(.GRACE(GRACE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(accept),
    .load_val(reload_count(wdata[CNT_FIELD_W-1:0])), .run_cmd(wdata[CMD_BIT]),
    .cnt(cnt), .running(running), .stage(stage), .rst_req(rst_req),
    .first_exp(first_exp), .second_exp(second_exp)
  );

  assign nmi = stage;

  always_comb begin
    if (addr == CTRL_A)      rdata = ctrl_q;
    else if (addr == STAT_A) rdata = status_word(cnt, stage, running);
    else                     rdata = '0;
  end

  // R3
  bad_key_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_q[CMD_BIT] && (wdata[KEY_LSB +: KEY_W] != ~ctrl_q[KEY_LSB +: KEY_W]))
      |=> ($stable(ctrl_q) && $stable(running)));
  // R8
  second_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    second_exp |=> (rst_req && !running && nmi));
  // R7
  first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_exp |=> (nmi && !rst_req));
endmodule

// File: tb/wdg_keyed_top_tb.sv
module wdg_keyed_top_tb;
  localparam int GRACE = 3;
  localparam logic [7:0] CTRL = 8'h40;
  localparam logic [7:0] STAT = 8'h44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = CTRL;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic nmi, rst_req;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdg_keyed_top #(.GRACE(GRACE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .nmi(nmi), .rst_req(rst_req)
  );

  // {is_tick, data, exp_cnt, exp_nmi, exp_run, req}
  // Control word: key [15:9], command bit 8, count [7:0].
  // Status word: count [8:0], nmi stage 12, running 13.
  localparam int NV = 11;
  localparam logic [47:0] VEC [0:NV-1] = '{
    {1'b0, 32'h0000_2B03, 9'd3,   1'b0, 1'b1, 4'd2},  // R2 R5 disarmed, any key
    {1'b1, 32'h0,         9'd2,   1'b0, 1'b1, 4'd6},  // R6 step
    {1'b0, 32'h0000_2B09, 9'd2,   1'b0, 1'b1, 4'd3},  // R3 same key dropped
    {1'b1, 32'h0,         9'd1,   1'b0, 1'b1, 4'd6},  // R6
    {1'b1, 32'h0,         9'd3,   1'b1, 1'b1, 4'd7},  // R7 first expiry
    {1'b1, 32'h0,         9'd2,   1'b1, 1'b1, 4'd7},  // R7 grace counts
    {1'b0, 32'h0000_D500, 9'd256, 1'b0, 1'b1, 4'd4},  // R4 R5 R9 inverse key, zero=256
    {1'b1, 32'h0,         9'd255, 1'b0, 1'b1, 4'd6},  // R6
    {1'b0, 32'h0000_2A05, 9'd5,   1'b0, 1'b0, 4'd4},  // R4 stop command
    {1'b1, 32'h0,         9'd5,   1'b0, 1'b0, 4'd6},  // R6 stopped ignores tick
    {1'b0, 32'h0000_0102, 9'd2,   1'b0, 1'b1, 4'd2}   // R2 disarmed again
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d, input bit with_tick);
    @(negedge clk); wr_en = 1'b1; addr = CTRL; wdata = d; tick = with_tick;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  function automatic logic [31:0] stat(input int c, input bit n, input bit r);
    logic [31:0] w;
    w = '0; w[8:0] = c[8:0]; w[12] = n; w[13] = r;
    return w;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    read_reg(CTRL, v); check("R1 ctrl", v, 32'h0);
    read_reg(STAT, v); check("R1 status", v, 32'h0);
    check("R1 nmi/rst", {30'b0, nmi, rst_req}, 32'h0);
    do_tick();
    read_reg(STAT, v); check("R1 tick while idle", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][47]) do_tick();
      else            do_write(VEC[i][46:15], 1'b0);
      read_reg(STAT, v);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), v,
            stat(int'(VEC[i][14:6]), VEC[i][5], VEC[i][4]));
      check($sformatf("R%0d vec%0d nmi", VEC[i][3:0], i), {31'b0, nmi}, {31'b0, VEC[i][5]});
    end

    // R3 stored word unchanged after a dropped write
    read_reg(CTRL, v); check("R3 ctrl held", v, 32'h0000_0102);

    // Run to first expiry then second: count 2 -> 1 -> nmi grace 3 -> 2 -> 1 -> reset
    do_tick(); do_tick();
    read_reg(STAT, v); check("R7 nmi stage", v, stat(GRACE, 1'b1, 1'b1));
    do_tick(); do_tick();
    // R8 second expiry pulse
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1;
    check("R8 pulse high", {31'b0, rst_req}, 32'h1);
    @(negedge clk); tick = 1'b0;
    @(posedge clk); #1;
    check("R8 pulse one cycle", {31'b0, rst_req}, 32'h0);
    @(negedge clk);
    read_reg(STAT, v); check("R8 stopped", v, stat(0, 1'b1, 1'b0));

    // R10 write with tick same cycle; key must be inverse of 0 -> 7F; also R9
    do_write(32'h0000_FF07, 1'b1);
    read_reg(STAT, v); check("R10 write wins", v, stat(7, 1'b0, 1'b1));
    check("R9 nmi cleared", {31'b0, nmi}, 32'h0);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_reg(STAT, v); check("R1 reset mid-run", v, 32'h0);
    read_reg(CTRL, v); check("R1 ctrl cleared", v, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule